// File: doc/BRIEF.md
# I2C Master Register and Byte-Queue Front End

This block is the host-facing side of an I2C master. A simple word-addressed host bus reaches a set of configuration registers: clock divider, control word, command, target address, queue control, queue fill count, interrupt enable and interrupt status. Two byte queues sit between the host and the bus engine. One carries bytes the host sends toward the engine. The other carries bytes the engine has received back to the host. The control word holds the transfer length in its upper half, with mode flags in the low bits.

Pulses from the engine set sticky status bits, and so do conditions on the queue levels. The host clears a status bit by writing a one to it. A single interrupt line is high whenever an enabled status bit is set. A write to the send-queue offset pushes one byte. A read of the receive-queue offset returns the oldest byte and removes it. A read of the receive-queue offset when that queue is empty returns zero and changes nothing.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset, every register reads zero except queue control, which reads 0x00008000 (high threshold = queue depth 128, low threshold 0). Both queues are empty, `irq` is low, `cmd_go` is low and `eng_tx_valid` is low.
- R2: The divider (offset 0x0) reads back its low 16 bits. The target address (0xA) reads back its low 10 bits. The control word (0x1) reads back bits 31:16 (length), 6 (enable), 4 (master), 1 (read) and 0 (10-bit addressing); all other control bits read zero. `ctl_word` carries the same value.
- R3: A write to offset 0x2 loads bits 7:0 into `cmd_word` and raises `cmd_go` for exactly the following cycle.
- R4: Bit 0 of offset 0x3 shows `eng_busy`; all other bits of 0x3 read zero, and writes to 0x3 have no effect.
- R5: A write to offset 0x4 pushes `hst_wdata[7:0]` into the 128-byte send queue. The engine sees the oldest byte on `eng_tx_data`, qualified by `eng_tx_valid`, and removes it with `eng_tx_pop`. Bytes are delivered in write order, and pushes made while the queue holds 128 bytes are dropped.
- R6: `eng_rx_push` stores `eng_rx_data` in the 128-byte receive queue. A host read of 0x5 returns the oldest byte in bits 7:0 and removes it. A read of 0x5 while the queue is empty returns zero and leaves the queue unchanged. Bits 7:0 of offset 0xC give the receive fill level.
- R7: Offset 0x6 stores the high threshold in bits 15:8 and the low threshold in bits 7:0. Writing bit 16 as one empties both queues in the same cycle. Bit 16 always reads zero.
- R8: Engine pulses set status bits in offset 0xE: bus error (bit 0), arbitration lost (bit 11), done (bit 12), address acknowledged (bit 13) and address not acknowledged (bit 25).
- R9: Status bit 2 is set while the receive fill level is at or above the high threshold. Status bit 3 is set when the engine removes the last byte from the send queue. Status bit 4 is set while either queue holds 128 bytes.
- R10: Writing offset 0xE clears the bits written as one and leaves the bits written as zero unchanged. A set condition in the same cycle as a clear wins, and the bit stays set.
- R11: `irq` is the OR of all status bits ANDed with their enable bits from offset 0xD. Offset 0xD reads back only the eight defined status positions (mask 0x0200381D).
- R12: Writing control bit 8 as one empties both queues and clears all status bits. Bit 8 itself is not stored, and the other control fields take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 5 | Word offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid during a read strobe |
| eng_busy | input | 1 | Engine busy level |
| eng_tx_pop | input | 1 | Engine removes the send-queue head |
| eng_tx_data | output | 8 | Send-queue head byte |
| eng_tx_valid | output | 1 | Send queue is not empty |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | 8 | Received byte |
| evt_bus_err | input | 1 | Bus error pulse |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_done | input | 1 | Transfer done pulse |
| evt_addr_ack | input | 1 | Address acknowledged pulse |
| evt_addr_nack | input | 1 | Address not acknowledged pulse |
| ctl_word | output | 32 | Stored control word |
| cmd_word | output | 8 | Last command byte |
| cmd_go | output | 1 | One-cycle pulse after a command write |
| div_word | output | 16 | Clock divider |
| tgt_word | output | 10 | Target address |
| irq | output | 1 | Interrupt request |

## Verification
The register table writes all-ones and then sparse patterns to each register. This separates correct bit masking from simple storage, and shows that the self-clearing control and flush bits are not retained. The queue tests push distinct byte values and watch their order. This exposes pointer and wrap errors over a full 128-byte pass, and shows that bytes beyond capacity are dropped. The status tests raise events one at a time, together, and in the same cycle as a clear. This tells a sticky write-one-to-clear bit apart from a level or a plain register, and confirms that a set outranks a clear. The enable mask and the level-driven threshold bit show whether `irq` follows the enabled status bits only.

// File: rtl/i2c_host_regs_pkg.sv
package i2c_host_regs_pkg;

   // word offsets seen by the host
   localparam int OFF_DIV  = 0;
   localparam int OFF_CTL  = 1;
   localparam int OFF_CMD  = 2;
   localparam int OFF_STAT = 3;
   localparam int OFF_TXQ  = 4;
   localparam int OFF_RXQ  = 5;
   localparam int OFF_QCTL = 6;
   localparam int OFF_TGT  = 10;
   localparam int OFF_QCNT = 12;
   localparam int OFF_IEN  = 13;
   localparam int OFF_IST  = 14;

   // status / enable bit positions
   localparam int IB_BUS_ERR   = 0;
   localparam int IB_RX_HI     = 2;
   localparam int IB_TX_EMPTY  = 3;
   localparam int IB_Q_FULL    = 4;
   localparam int IB_ARB_LOST  = 11;
   localparam int IB_DONE      = 12;
   localparam int IB_ADDR_ACK  = 13;
   localparam int IB_ADDR_NACK = 25;

   localparam logic [31:0] IRQ_IMPL =
      (32'd1 << IB_BUS_ERR)  | (32'd1 << IB_RX_HI)    | (32'd1 << IB_TX_EMPTY) |
      (32'd1 << IB_Q_FULL)   | (32'd1 << IB_ARB_LOST) | (32'd1 << IB_DONE)     |
      (32'd1 << IB_ADDR_ACK) | (32'd1 << IB_ADDR_NACK);

   // control word fields
   localparam int CB_TEN    = 0;
   localparam int CB_RD     = 1;
   localparam int CB_MASTER = 4;
   localparam int CB_EN     = 6;
   localparam int CB_SRST   = 8;
   localparam int CB_LEN_LO = 16;
   localparam int LEN_W     = 16;

   // queue control fields
   localparam int QB_LO_LO  = 0;
   localparam int QB_HI_LO  = 8;
   localparam int QB_FLUSH  = 16;
   localparam int THR_W     = 8;

endpackage

// File: rtl/i2c_host_byte_fifo.sv
module i2c_host_byte_fifo #(
   parameter int DEPTH = 128,
   parameter int DW    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        push,
   input  logic [DW-1:0]               wdata,
   input  logic                        pop,
   output logic [DW-1:0]               head,
   output logic [$clog2(DEPTH+1)-1:0]  count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);

   if (DEPTH < 2) begin : g_depth_chk
      $error("i2c_host_byte_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign do_push = push && !flush && (cnt != CNT_W'(DEPTH));
   assign do_pop  = pop  && !flush && (cnt != '0);

   // pointer wrap: free for a power-of-two depth, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign head  = mem[rptr];
   assign count = cnt;

   // R5
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R6
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && (cnt == '0) && !push && !flush) |=> (cnt == '0));

   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0));

endmodule

// File: rtl/i2c_host_irq_status.sv
module i2c_host_irq_status #(
   parameter int          W    = 32,
   parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic [W-1:0] set_vec,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   input  logic         en_we,
   input  logic [W-1:0] en_din,
   output logic [W-1:0] status,
   output logic [W-1:0] enable,
   output logic         irq
);
   if (W < 1 || W > 32) begin : g_w_chk
      $error("i2c_host_irq_status: W must be 1..32");
   end

   localparam logic [W-1:0] MASK = IMPL[W-1:0];

   logic [W-1:0] st_q, en_q, st_d, clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   // set outranks a same-cycle clear; soft clear outranks both
   always_comb begin
      if (soft_clr) st_d = '0;
      else          st_d = ((st_q & ~clr_eff) | set_vec) & MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
         en_q <= '0;
      end else begin
         st_q <= st_d;
         if (en_we) en_q <= en_din & MASK;
      end
   end

   assign status = st_q;
   assign enable = en_q;
   assign irq    = |(st_q & en_q);

   // R10
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !soft_clr) |=> ((status & $past(clr_mask & ~set_vec)) == '0));

   // R8
   set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_clr && (|(set_vec & MASK))) |=>
      ((status & $past(set_vec & MASK)) == $past(set_vec & MASK)));

   // R12
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (status == '0));

endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
   import i2c_host_regs_pkg::*;
#(
   parameter int FIFO_DEPTH = 128,
   parameter int ADDR_W     = 5,
   parameter int DIV_W      = 16,
   parameter int TGT_W      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [31:0]       hst_wdata,
   output logic [31:0]       hst_rdata,
   input  logic              eng_busy,
   input  logic              eng_tx_pop,
   output logic [7:0]        eng_tx_data,
   output logic              eng_tx_valid,
   input  logic              eng_rx_push,
   input  logic [7:0]        eng_rx_data,
   input  logic              evt_bus_err,
   input  logic              evt_arb_lost,
   input  logic              evt_done,
   input  logic              evt_addr_ack,
   input  logic              evt_addr_nack,
   output logic [31:0]       ctl_word,
   output logic [7:0]        cmd_word,
   output logic              cmd_go,
   output logic [DIV_W-1:0]  div_word,
   output logic [TGT_W-1:0]  tgt_word,
   output logic              irq
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
   localparam int CMP_W = (CNT_W > THR_W) ? CNT_W + 1 : THR_W + 1;

   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 255) begin : g_depth_chk
      $error("i2c_host_regs: FIFO_DEPTH must be 2..255");
   end
   if (ADDR_W < 4) begin : g_addr_chk
      $error("i2c_host_regs: ADDR_W must reach offset 0xE");
   end
   if (DIV_W < 1 || DIV_W > 32) begin : g_div_chk
      $error("i2c_host_regs: DIV_W must be 1..32");
   end
   if (TGT_W < 7 || TGT_W > 16) begin : g_tgt_chk
      $error("i2c_host_regs: TGT_W must be 7..16");
   end

   // ---------------- decode ----------------
   logic wr_hit, rd_hit;
   logic we_div, we_ctl, we_cmd, we_txq, we_qctl, we_tgt, we_ien, we_ist;
   logic rd_rxq;

   assign wr_hit  = hst_sel &&  hst_wr;
   assign rd_hit  = hst_sel && !hst_wr;
   assign we_div  = wr_hit && (hst_addr == ADDR_W'(OFF_DIV));
   assign we_ctl  = wr_hit && (hst_addr == ADDR_W'(OFF_CTL));
   assign we_cmd  = wr_hit && (hst_addr == ADDR_W'(OFF_CMD));
   assign we_txq  = wr_hit && (hst_addr == ADDR_W'(OFF_TXQ));
   assign we_qctl = wr_hit && (hst_addr == ADDR_W'(OFF_QCTL));
   assign we_tgt  = wr_hit && (hst_addr == ADDR_W'(OFF_TGT));
   assign we_ien  = wr_hit && (hst_addr == ADDR_W'(OFF_IEN));
   assign we_ist  = wr_hit && (hst_addr == ADDR_W'(OFF_IST));
   assign rd_rxq  = rd_hit && (hst_addr == ADDR_W'(OFF_RXQ));

   logic soft_rst, q_flush;
   assign soft_rst = we_ctl  && hst_wdata[CB_SRST];
   assign q_flush  = soft_rst || (we_qctl && hst_wdata[QB_FLUSH]);

   // ---------------- configuration registers ----------------
   logic [DIV_W-1:0] div_q;
   logic [LEN_W-1:0] len_q;
   logic             en_q, master_q, rd_q, ten_q;
   logic [7:0]       cmd_q;
   logic             go_q;
   logic [TGT_W-1:0] tgt_q;
   logic [THR_W-1:0] hi_q, lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         len_q    <= '0;
         en_q     <= 1'b0;
         master_q <= 1'b0;
         rd_q     <= 1'b0;
         ten_q    <= 1'b0;
         cmd_q    <= '0;
         go_q     <= 1'b0;
         tgt_q    <= '0;
         hi_q     <= THR_W'(FIFO_DEPTH);
         lo_q     <= '0;
      end else begin
         go_q <= we_cmd;
         if (we_div) div_q <= hst_wdata[DIV_W-1:0];
         if (we_ctl) begin
            len_q    <= hst_wdata[CB_LEN_LO +: LEN_W];
            en_q     <= hst_wdata[CB_EN];
            master_q <= hst_wdata[CB_MASTER];
            rd_q     <= hst_wdata[CB_RD];
            ten_q    <= hst_wdata[CB_TEN];
         end
         if (we_cmd)  cmd_q <= hst_wdata[7:0];
         if (we_tgt)  tgt_q <= hst_wdata[TGT_W-1:0];
         if (we_qctl) begin
            hi_q <= hst_wdata[QB_HI_LO +: THR_W];
            lo_q <= hst_wdata[QB_LO_LO +: THR_W];
         end
      end
   end

   always_comb begin
      ctl_word            = '0;
      ctl_word[CB_LEN_LO +: LEN_W] = len_q;
      ctl_word[CB_EN]     = en_q;
      ctl_word[CB_MASTER] = master_q;
      ctl_word[CB_RD]     = rd_q;
      ctl_word[CB_TEN]    = ten_q;
   end

   assign div_word = div_q;
   assign cmd_word = cmd_q;
   assign cmd_go   = go_q;
   assign tgt_word = tgt_q;

   // ---------------- byte queues ----------------
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic [7:0]       tx_head, rx_head;

   i2c_host_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (q_flush),
      .push  (we_txq),
      .wdata (hst_wdata[7:0]),
      .pop   (eng_tx_pop),
      .head  (tx_head),
      .count (tx_cnt)
   );

   i2c_host_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (q_flush),
      .push  (eng_rx_push),
      .wdata (eng_rx_data),
      .pop   (rd_rxq),
      .head  (rx_head),
      .count (rx_cnt)
   );

   assign eng_tx_data  = tx_head;
   assign eng_tx_valid = (tx_cnt != '0);

   // ---------------- status sources ----------------
   logic        tx_last_out, rx_at_hi, any_full;
   logic [31:0] set_vec, ist, ien;

   assign tx_last_out = eng_tx_pop && (tx_cnt == CNT_W'(1)) && !we_txq && !q_flush;
   assign rx_at_hi    = CMP_W'(rx_cnt) >= CMP_W'(hi_q);
   assign any_full    = (tx_cnt == CNT_W'(FIFO_DEPTH)) || (rx_cnt == CNT_W'(FIFO_DEPTH));

   always_comb begin
      set_vec               = '0;
      set_vec[IB_BUS_ERR]   = evt_bus_err;
      set_vec[IB_RX_HI]     = rx_at_hi;
      set_vec[IB_TX_EMPTY]  = tx_last_out;
      set_vec[IB_Q_FULL]    = any_full;
      set_vec[IB_ARB_LOST]  = evt_arb_lost;
      set_vec[IB_DONE]      = evt_done;
      set_vec[IB_ADDR_ACK]  = evt_addr_ack;
      set_vec[IB_ADDR_NACK] = evt_addr_nack;
   end

   i2c_host_irq_status #(.W(32), .IMPL(IRQ_IMPL)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_rst),
      .set_vec  (set_vec),
      .clr_we   (we_ist),
      .clr_mask (hst_wdata),
      .en_we    (we_ien),
      .en_din   (hst_wdata),
      .status   (ist),
      .enable   (ien),
      .irq      (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      hst_rdata = '0;
      if (rd_hit) begin
         case (hst_addr)
            ADDR_W'(OFF_DIV):  hst_rdata = 32'(div_q);
            ADDR_W'(OFF_CTL):  hst_rdata = ctl_word;
            ADDR_W'(OFF_CMD):  hst_rdata = {24'd0, cmd_q};
            ADDR_W'(OFF_STAT): hst_rdata = {31'd0, eng_busy};
            ADDR_W'(OFF_RXQ):  hst_rdata = {24'd0, (rx_cnt != '0) ? rx_head : 8'd0};
            ADDR_W'(OFF_QCTL): hst_rdata = {16'd0, hi_q, lo_q};
            ADDR_W'(OFF_TGT):  hst_rdata = 32'(tgt_q);
            ADDR_W'(OFF_QCNT): hst_rdata = 32'(rx_cnt);
            ADDR_W'(OFF_IEN):  hst_rdata = ien;
            ADDR_W'(OFF_IST):  hst_rdata = ist;
            default:           hst_rdata = '0;
         endcase
      end
   end

   // R3
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_cmd |=> (cmd_go && (cmd_word == $past(hst_wdata[7:0]))));

   // R6
   rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxq && (rx_cnt != '0) && !eng_rx_push && !q_flush) |=>
      (rx_cnt == $past(rx_cnt) - 1'b1));

endmodule

// File: tb/i2c_host_regs_bench.sv
module i2c_host_regs_bench;
   localparam int PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_sel = 1'b0, hst_wr = 1'b0;
   logic [4:0]  hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_data = '0, eng_tx_data;
   logic        eng_tx_valid;
   logic        evt_bus_err = 1'b0, evt_arb_lost = 1'b0, evt_done = 1'b0;
   logic        evt_addr_ack = 1'b0, evt_addr_nack = 1'b0;
   logic [31:0] ctl_word;
   logic [7:0]  cmd_word;
   logic        cmd_go;
   logic [15:0] div_word;
   logic [9:0]  tgt_word;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(PER/2) clk = ~clk;

   i2c_host_regs u_i2c_host_regs (
      .clk(clk), .rst_n(rst_n),
      .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .evt_bus_err(evt_bus_err), .evt_arb_lost(evt_arb_lost), .evt_done(evt_done),
      .evt_addr_ack(evt_addr_ack), .evt_addr_nack(evt_addr_nack),
      .ctl_word(ctl_word), .cmd_word(cmd_word), .cmd_go(cmd_go),
      .div_word(div_word), .tgt_word(tgt_word), .irq(irq)
   );

   // {offset, write value, expected readback}
   localparam int NV = 9;
   localparam logic [68:0] VEC [NV] = '{
      {5'h00, 32'hFFFF_FFFF, 32'h0000_FFFF},   // R2 divider width
      {5'h00, 32'h0000_1234, 32'h0000_1234},   // R2
      {5'h01, 32'hFFFF_FFFF, 32'hFFFF_0053},   // R2 control mask, bit 8 not kept
      {5'h01, 32'h0022_0040, 32'h0022_0040},   // R2
      {5'h0A, 32'h0000_FFFF, 32'h0000_03FF},   // R2 target width
      {5'h0D, 32'hFFFF_FFFF, 32'h0200_381D},   // R11 enable mask
      {5'h0D, 32'h0000_0000, 32'h0000_0000},   // R11
      {5'h03, 32'hFFFF_FFFF, 32'h0000_0000},   // R4 write ignored, busy low
      {5'h06, 32'h0000_1005, 32'h0000_1005}    // R7 thresholds
   };
   localparam int VREQ [NV] = '{2, 2, 2, 2, 2, 11, 11, 4, 7};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic host_write(input logic [4:0] a, input logic [31:0] d);
      hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      @(posedge clk);
      @(negedge clk);
      hst_sel = 1'b0; hst_wr = 1'b0;
   endtask

   task automatic host_read(input logic [4:0] a, output logic [31:0] d);
      hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
      #(PER/4);
      d = hst_rdata;
      @(posedge clk);
      @(negedge clk);
      hst_sel = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_data = b;
      @(posedge clk);
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic tx_pop();
      eng_tx_pop = 1'b1;
      @(posedge clk);
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] rv;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // ---- R1 reset state ----
      host_read(5'h06, rv); chk("R1 qctl", rv, 32'h0000_8000);
      host_read(5'h0E, rv); chk("R1 status", rv, 32'h0);
      host_read(5'h0C, rv); chk("R1 rx count", rv, 32'h0);
      host_read(5'h01, rv); chk("R1 control", rv, 32'h0);
      chk("R1 irq/go/txvalid", {29'd0, irq, cmd_go, eng_tx_valid}, 32'h0);

      // ---- register table ----
      for (int i = 0; i < NV; i++) begin
         host_write(VEC[i][68:64], VEC[i][63:32]);
         host_read(VEC[i][68:64], rv);
         chk($sformatf("R%0d table row %0d", VREQ[i], i), rv, VEC[i][31:0]);
         chk($sformatf("R%0d table row %0d irq", VREQ[i], i), {31'd0, irq}, 32'h0);
      end
      chk("R2 ctl_word port", ctl_word, 32'h0022_0040);
      chk("R2 div/tgt ports", {div_word, 6'd0, tgt_word}, {16'h1234, 6'd0, 10'h3FF});

      // ---- R3 command pulse ----
      host_write(5'h02, 32'h0000_00C0);
      chk("R3 go high", {23'd0, cmd_go, cmd_word}, {23'd0, 1'b1, 8'hC0});
      idle(1);
      chk("R3 go one cycle", {31'd0, cmd_go}, 32'h0);

      // ---- R4 busy ----
      eng_busy = 1'b1;
      host_read(5'h03, rv); chk("R4 busy", rv, 32'h1);
      eng_busy = 1'b0;

      // ---- R6 receive queue ----
      rx_push(8'h5A); rx_push(8'h6B); rx_push(8'h7C);
      host_read(5'h0C, rv); chk("R6 count 3", rv, 32'd3);
      host_read(5'h05, rv); chk("R6 pop 1", rv, 32'h5A);
      host_read(5'h05, rv); chk("R6 pop 2", rv, 32'h6B);
      host_read(5'h05, rv); chk("R6 pop 3", rv, 32'h7C);
      host_read(5'h05, rv); chk("R6 empty read", rv, 32'h0);
      host_read(5'h0C, rv); chk("R6 count after empty read", rv, 32'h0);

      // ---- R9 / R11 high threshold ----
      host_write(5'h06, 32'h0000_0200);
      host_write(5'h0E, 32'hFFFF_FFFF);
      host_write(5'h0D, 32'h0000_0004);
      rx_push(8'h11); idle(1);
      chk("R9 below threshold irq", {31'd0, irq}, 32'h0);
      rx_push(8'h22); idle(1);
      host_read(5'h0E, rv); chk("R9 at threshold", rv, 32'h4);
      chk("R11 irq on enabled bit", {31'd0, irq}, 32'h1);
      host_read(5'h05, rv); host_read(5'h05, rv);
      host_write(5'h0E, 32'h0000_0004); idle(1);
      host_read(5'h0E, rv); chk("R9 cleared below threshold", rv, 32'h0);
      chk("R11 irq low", {31'd0, irq}, 32'h0);
      host_write(5'h06, 32'h0000_1000);

      // ---- R8 events ----
      host_write(5'h0D, 32'h0);
      evt_bus_err = 1; evt_arb_lost = 1; evt_done = 1; evt_addr_ack = 1; evt_addr_nack = 1;
      @(posedge clk); @(negedge clk);
      evt_bus_err = 0; evt_arb_lost = 0; evt_done = 0; evt_addr_ack = 0; evt_addr_nack = 0;
      host_read(5'h0E, rv); chk("R8 event bits", rv, 32'h0200_3801);
      chk("R11 masked irq low", {31'd0, irq}, 32'h0);
      host_write(5'h0D, 32'h0000_1000);
      chk("R11 done enabled irq", {31'd0, irq}, 32'h1);

      // ---- R10 write-one-to-clear ----
      host_write(5'h0E, 32'h0000_1001);
      host_read(5'h0E, rv); chk("R10 partial clear", rv, 32'h0200_2800);
      chk("R11 irq after clear", {31'd0, irq}, 32'h0);
      hst_sel = 1; hst_wr = 1; hst_addr = 5'h0E; hst_wdata = 32'h1; evt_bus_err = 1;
      @(posedge clk); @(negedge clk);
      hst_sel = 0; hst_wr = 0; evt_bus_err = 0;
      host_read(5'h0E, rv); chk("R10 set wins over clear", rv, 32'h0200_2801);
      host_write(5'h0E, 32'hFFFF_FFFF);
      host_read(5'h0E, rv); chk("R10 clear all", rv, 32'h0);

      // ---- R5 send queue ----
      host_write(5'h04, 32'hFFFF_FFA1);
      host_write(5'h04, 32'h0000_00B2);
      host_write(5'h04, 32'h0000_00C3);
      chk("R5 head 1", {23'd0, eng_tx_valid, eng_tx_data}, {23'd0, 1'b1, 8'hA1});
      tx_pop();
      chk("R5 head 2", {24'd0, eng_tx_data}, 32'hB2);
      tx_pop();
      chk("R5 head 3", {24'd0, eng_tx_data}, 32'hC3);
      tx_pop();
      chk("R5 drained", {31'd0, eng_tx_valid}, 32'h0);
      host_read(5'h0E, rv); chk("R9 last byte taken", rv, 32'h8);
      host_write(5'h0E, 32'hFFFF_FFFF);
      for (int k = 0; k < 130; k++) host_write(5'h04, k);
      idle(1);
      host_read(5'h0E, rv); chk("R9 queue full", rv, 32'h10);
      bad = 0;
      for (int k = 0; k < 128; k++) begin
         if (eng_tx_data !== 8'(k) || eng_tx_valid !== 1'b1) bad++;
         tx_pop();
      end
      chk("R5 order over full pass", bad, 0);
      chk("R5 extra pushes dropped", {31'd0, eng_tx_valid}, 32'h0);
      host_read(5'h0E, rv); chk("R9 full then empty", rv, 32'h18);
      host_write(5'h0E, 32'hFFFF_FFFF);

      // ---- R7 flush ----
      host_write(5'h04, 32'h1); host_write(5'h04, 32'h2);
      rx_push(8'h33); rx_push(8'h44);
      host_write(5'h06, 32'h0001_1005);
      host_read(5'h0C, rv); chk("R7 rx flushed", rv, 32'h0);
      chk("R7 tx flushed", {31'd0, eng_tx_valid}, 32'h0);
      host_read(5'h06, rv); chk("R7 thresholds kept, flush bit clear", rv, 32'h0000_1005);

      // ---- R12 soft reset ----
      host_write(5'h04, 32'h9); host_write(5'h04, 32'hA);
      rx_push(8'h55);
      evt_done = 1; @(posedge clk); @(negedge clk); evt_done = 0;
      host_read(5'h0E, rv); chk("R12 status before", rv, 32'h1000);
      host_write(5'h01, 32'h0005_0150);
      host_read(5'h01, rv); chk("R12 control without bit 8", rv, 32'h0005_0050);
      host_read(5'h0C, rv); chk("R12 rx emptied", rv, 32'h0);
      chk("R12 tx emptied", {31'd0, eng_tx_valid}, 32'h0);
      host_read(5'h0E, rv); chk("R12 status cleared", rv, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (R1..R12 run): actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule